// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block delivers message-signalled interrupts for a single bus function. It keeps a vector table of up to 32 entries and a pending-bit word together in one 4 KB register page. Each entry gives a 64-bit message address, a 32-bit message payload and a per-vector mask. A control byte holds a global enable and a function-wide mask. Device logic pulses a per-vector request. The controller then either launches a message write on a valid/ready output, or, if the vector is masked, records the request as a pending bit.

When a mask is cleared, pending work is delivered. This applies to a table write that unmasks one vector and to a control-byte write that clears the function mask. The deferred messages are sent lowest vector first. A control-byte write while enabled also pulses a strobe that tells the legacy level interrupt to deassert. The device side can release a vector, and releasing it drops that vector's pending bit.

Top module: `msixVectorCtrl`

## Requirements
- R1: After reset every table dword reads 0 except each vector-control dword, which reads 1 (masked). The pending word reads 0, the control byte reads 0x00 and msgValid is low.
- R2: Page decode: entry e starts at byte 16*e and holds address low (+0x0), address high (+0x4), payload (+0x8) and vector control (+0xC), whose bit 0 is the mask. Address bits [1:0] are ignored. Entries at or beyond NUM_VEC read 0 and ignore writes.
- R3: Control byte bit 7 is enable and bit 6 is function mask. Both are writable and read back, and all other bits read 0.
- R4: A request on an enabled, unmasked vector emits one message carrying {address high, address low} and the entry's payload.
- R5: A request on a vector that is masked (by its own bit 0 or by the function mask) sets bit v of the pending word at byte offset 0x800 and emits nothing.
- R6: While enabled, a write to an entry whose vector is then unmasked and pending clears that pending bit and emits the vector's message.
- R7: A control-byte write that leaves enable set pulses intxDeassert for one cycle. If the function mask is then clear, every pending unmasked vector is delivered, lowest index first.
- R8: While enable is clear, requests change neither the pending word nor the output, no new message starts, and control writes give no intxDeassert pulse.
- R9: A vecRelease pulse clears that vector's pending bit without emitting a message.
- R10: While msgValid is high and msgReady low, msgValid stays high and msgAddr and msgData hold their values.
- R11: Writes to the pending word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Page write strobe (32-bit) |
| regAddr | input | 12 | Byte address within the page |
| regWrData | input | 32 | Page write data |
| regRdData | output | 32 | Page read data for regAddr (combinational) |
| ctrlWrEn | input | 1 | Control byte write strobe |
| ctrlWrData | input | 8 | Control byte write value |
| ctrlRdData | output | 8 | Control byte value |
| irqReq | input | NUM_VEC | Per-vector request pulses |
| vecRelease | input | NUM_VEC | Per-vector release pulses |
| msgValid | output | 1 | Message write valid |
| msgReady | input | 1 | Message write accepted |
| msgAddr | output | 64 | Message address |
| msgData | output | 32 | Message payload |
| intxDeassert | output | 1 | One-cycle strobe to deassert the legacy interrupt |

## Verification
On every cycle the assertions check the output handshake (payload held under backpressure). They also check that no message starts while disabled, that every intxDeassert follows a control write, and that every message start follows an enabled cycle. Only the bench scenarios can show the deferred paths. These are a masked request becoming pending, an unmask write releasing exactly that vector, and a function-mask clear draining several pending vectors in ascending order. The same holds for decode details such as ignored low address bits, out-of-range entries, the read-only pending word and release clearing a pending bit.

// File: rtl/msixPkg.sv
package msixPkg;
  localparam int MAX_VEC = 32;
  localparam int VIDX_W = $clog2(MAX_VEC);
  localparam int PAGE_AW = 12;

  // control -> datapath strobes
  typedef struct packed {
    logic              launch;
    logic [VIDX_W-1:0] launchVec;
  } dpStrobeT;

  function automatic logic [VIDX_W-1:0] lowestIdx(input logic [MAX_VEC-1:0] v);
    logic [VIDX_W-1:0] idx;
    idx = '0;
    for (int i = MAX_VEC - 1; i >= 0; i--) begin
      if (v[i]) idx = VIDX_W'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/msixData.sv
module msixData
  import msixPkg::*;
#(
  parameter int NUM_VEC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [PAGE_AW-1:0] regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic [NUM_VEC-1:0] pending,
  input  dpStrobeT           strobe,
  output logic [NUM_VEC-1:0] vecMask,
  output logic [NUM_VEC-1:0] tblWrHit,
  output logic [63:0]        msgAddr,
  output logic [31:0]        msgData
);
  localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic [31:0] addrLo [NUM_VEC];
  logic [31:0] addrHi [NUM_VEC];
  logic [31:0] payload[NUM_VEC];
  logic [31:0] vecCtl [NUM_VEC];

  logic             isPba;
  logic [6:0]       entry;
  logic [1:0]       dword;
  logic             entryHit;
  logic [IDX_W-1:0] entIdx;
  logic [IDX_W-1:0] launchIdx;

  assign isPba     = regAddr[11];
  assign entry     = regAddr[10:4];
  assign dword     = regAddr[3:2];
  assign entryHit  = !isPba && (int'(entry) < NUM_VEC);
  assign entIdx    = entry[IDX_W-1:0];
  assign launchIdx = strobe.launchVec[IDX_W-1:0];

  generate
    for (genvar g = 0; g < NUM_VEC; g++) begin : gMask
      assign vecMask[g]  = vecCtl[g][0];
      assign tblWrHit[g] = regWrEn && entryHit && (int'(entIdx) == g);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_VEC; i++) begin
        addrLo[i]  <= '0;
        addrHi[i]  <= '0;
        payload[i] <= '0;
        vecCtl[i]  <= 32'd1;
      end
      msgAddr <= '0;
      msgData <= '0;
    end else begin
      if (regWrEn && entryHit) begin
        case (dword)
          2'd0:    addrLo[entIdx]  <= regWrData;
          2'd1:    addrHi[entIdx]  <= regWrData;
          2'd2:    payload[entIdx] <= regWrData;
          default: vecCtl[entIdx]  <= regWrData;
        endcase
      end
      if (strobe.launch) begin
        msgAddr <= {addrHi[launchIdx], addrLo[launchIdx]};
        msgData <= payload[launchIdx];
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (entryHit) begin
      case (dword)
        2'd0:    regRdData = addrLo[entIdx];
        2'd1:    regRdData = addrHi[entIdx];
        2'd2:    regRdData = payload[entIdx];
        default: regRdData = vecCtl[entIdx];
      endcase
    end else if (isPba && regAddr[10:2] == '0) begin
      regRdData[NUM_VEC-1:0] = pending;
    end
  end
endmodule

// File: rtl/msixCtrl.sv
module msixCtrl
  import msixPkg::*;
#(
  parameter int NUM_VEC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlWrEn,
  input  logic [7:0]         ctrlWrData,
  output logic [7:0]         ctrlByte,
  input  logic [NUM_VEC-1:0] irqReq,
  input  logic [NUM_VEC-1:0] vecRelease,
  input  logic [NUM_VEC-1:0] vecMask,
  input  logic [NUM_VEC-1:0] tblWrHit,
  input  logic               msgReady,
  output logic               msgValid,
  output logic               intxDeassert,
  output logic [NUM_VEC-1:0] pending,
  output dpStrobeT           strobe
);
  logic               enReg, fmaskReg, outValid, ctrlWrQ;
  logic [NUM_VEC-1:0] sendReq, rescanOne;
  logic [NUM_VEC-1:0] effMask, rescan, moveOut, reqLive, launchOh;
  logic [MAX_VEC-1:0] sendWide;
  logic               launch;
  logic [VIDX_W-1:0]  launchIdx;

  assign ctrlByte     = {enReg, fmaskReg, 6'b0};
  assign msgValid     = outValid;
  assign intxDeassert = ctrlWrQ && enReg;

  always_comb begin
    effMask  = vecMask | {NUM_VEC{fmaskReg}};
    rescan   = rescanOne | {NUM_VEC{ctrlWrQ && enReg && !fmaskReg}};
    moveOut  = enReg ? (rescan & pending & ~effMask) : '0;
    reqLive  = enReg ? irqReq : '0;
    sendWide = '0;
    sendWide[NUM_VEC-1:0] = sendReq;
    launchIdx = lowestIdx(sendWide);
    launch   = enReg && (|sendReq) && (!outValid || msgReady);
    launchOh = '0;
    if (launch) launchOh[launchIdx] = 1'b1;
    strobe.launch    = launch;
    strobe.launchVec = launchIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg     <= 1'b0;
      fmaskReg  <= 1'b0;
      outValid  <= 1'b0;
      ctrlWrQ   <= 1'b0;
      sendReq   <= '0;
      rescanOne <= '0;
      pending   <= '0;
    end else begin
      if (ctrlWrEn) begin
        enReg    <= ctrlWrData[7];
        fmaskReg <= ctrlWrData[6];
      end
      ctrlWrQ   <= ctrlWrEn;
      rescanOne <= tblWrHit;
      pending   <= (pending | (reqLive & effMask)) & ~moveOut & ~vecRelease;
      sendReq   <= enReg ? ((sendReq | (reqLive & ~effMask) | moveOut) & ~launchOh) : '0;
      if (launch)        outValid <= 1'b1;
      else if (msgReady) outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/msixVectorCtrl.sv
module msixVectorCtrl
  import msixPkg::*;
#(
  parameter int NUM_VEC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [11:0]        regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic               ctrlWrEn,
  input  logic [7:0]         ctrlWrData,
  output logic [7:0]         ctrlRdData,
  input  logic [NUM_VEC-1:0] irqReq,
  input  logic [NUM_VEC-1:0] vecRelease,
  output logic               msgValid,
  input  logic               msgReady,
  output logic [63:0]        msgAddr,
  output logic [31:0]        msgData,
  output logic               intxDeassert
);
  dpStrobeT           strobe;
  logic [NUM_VEC-1:0] pending, vecMask, tblWrHit;

  msixCtrl #(.NUM_VEC(NUM_VEC)) uCtrl (
    .clk(clk), .rstN(rstN),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData), .ctrlByte(ctrlRdData),
    .irqReq(irqReq), .vecRelease(vecRelease),
    .vecMask(vecMask), .tblWrHit(tblWrHit),
    .msgReady(msgReady), .msgValid(msgValid), .intxDeassert(intxDeassert),
    .pending(pending), .strobe(strobe)
  );

  msixData #(.NUM_VEC(NUM_VEC)) uData (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .pending(pending), .strobe(strobe),
    .vecMask(vecMask), .tblWrHit(tblWrHit),
    .msgAddr(msgAddr), .msgData(msgData)
  );
endmodule

// File: rtl/msixVectorCtrlChk.sv
module msixVectorCtrlChk (
  input logic        clk,
  input logic        rstN,
  input logic        ctrlWrEn,
  input logic [7:0]  ctrlRdData,
  input logic        msgValid,
  input logic        msgReady,
  input logic [63:0] msgAddr,
  input logic [31:0] msgData,
  input logic        intxDeassert
);
  // R10
  hold_payload_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgReady |=> msgValid && $stable(msgAddr) && $stable(msgData));

  // R8
  no_launch_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlRdData[7] && !msgValid |=> !msgValid);

  // R7
  intx_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    intxDeassert |-> $past(ctrlWrEn));

  // R4
  rise_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(msgValid) |-> $past(ctrlRdData[7]));
endmodule

bind msixVectorCtrl msixVectorCtrlChk uChk (
  .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlRdData(ctrlRdData),
  .msgValid(msgValid), .msgReady(msgReady), .msgAddr(msgAddr),
  .msgData(msgData), .intxDeassert(intxDeassert)
);

// File: tb/msixVectorCtrl_test.sv
`timescale 1ns/1ps
module msixVectorCtrl_test;
  localparam int NV = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [11:0]   regAddr = '0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic          ctrlWrEn = 1'b0;
  logic [7:0]    ctrlWrData = '0;
  logic [7:0]    ctrlRdData;
  logic [NV-1:0] irqReq = '0;
  logic [NV-1:0] vecRelease = '0;
  logic          msgValid;
  logic          msgReady = 1'b1;
  logic [63:0]   msgAddr;
  logic [31:0]   msgData;
  logic          intxDeassert;

  int errors = 0;
  int checks = 0;
  int msgCount = 0;
  int intxCount = 0;
  logic [95:0] expQ[$];

  always #2 clk = ~clk;

  msixVectorCtrl #(.NUM_VEC(NV)) uut (.*);

  task automatic check(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: a transfer completes at the next edge
  always @(negedge clk) begin
    if (rstN && intxDeassert) intxCount++;
    if (rstN && msgValid && msgReady) begin
      msgCount++;
      if (expQ.size() == 0) begin
        check(1'b0, "R4 unexpected message", {msgAddr, msgData}, '0);
      end else begin
        logic [95:0] e;
        e = expQ.pop_front();
        check({msgAddr, msgData} == e, "R4/R7 message content/order", {msgAddr, msgData}, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic ctrlWrite(input logic [7:0] d);
    @(negedge clk);
    ctrlWrData = d; ctrlWrEn = 1'b1;
    @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  task automatic pulseIrq(input int v);
    @(negedge clk);
    irqReq[v] = 1'b1;
    @(negedge clk);
    irqReq = '0;
  endtask

  task automatic pushExp(input logic [63:0] a, input logic [31:0] d);
    expQ.push_back({a, d});
  endtask

  localparam logic [63:0] A2 = 64'h0000_00A2_FEE0_0020;
  localparam logic [63:0] A3 = 64'h0000_0000_FEE0_0030;

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int mc, ic;
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1 reset state
    check(ctrlRdData == 8'h00, "R1 control byte", ctrlRdData, 0);
    check(!msgValid, "R1 msgValid", msgValid, 0);
    regRead(12'h00C, rd); check(rd == 1, "R1 vector 0 masked", rd, 1);
    regRead(12'h1FC, rd); check(rd == 1, "R1 vector 31 masked", rd, 1);
    regRead(12'h050, rd); check(rd == 0, "R1 entry 5 address", rd, 0);
    regRead(12'h800, rd); check(rd == 0, "R1 pending word", rd, 0);

    // R8 disabled: request ignored
    ic = intxCount;
    ctrlWrite(8'h00);
    pulseIrq(2); idle(5);
    regRead(12'h800, rd); check(rd == 0, "R8 pending while disabled", rd, 0);
    check(msgCount == 0, "R8 no message while disabled", msgCount, 0);
    check(intxCount == ic, "R8 no intx pulse while disabled", intxCount, ic);

    // R3 enable
    ctrlWrite(8'h80); idle(2);
    check(ctrlRdData == 8'h80, "R3 control readback", ctrlRdData, 8'h80);
    check(intxCount == ic + 1, "R7 intx pulse on control write", intxCount, ic + 1);

    // R2 program entries, low address bits ignored
    regWrite(12'h021, A2[31:0]);
    regWrite(12'h024, A2[63:32]);
    regWrite(12'h02A, 32'h42);
    regWrite(12'h030, A3[31:0]);
    regWrite(12'h034, A3[63:32]);
    regWrite(12'h038, 32'h43);
    regWrite(12'h03C, 32'h0);
    regRead(12'h023, rd); check(rd == A2[31:0], "R2 low address bits ignored", rd, A2[31:0]);
    regWrite(12'h200, 32'hDEAD_BEEF);
    regRead(12'h200, rd); check(rd == 0, "R2 entry beyond range reads 0", rd, 0);
    idle(4);
    check(msgCount == 0, "R6 unmask without pending sends nothing", msgCount, 0);

    // R5 masked request -> pending
    pulseIrq(2); idle(5);
    regRead(12'h800, rd); check(rd == 32'h4, "R5 pending bit 2", rd, 32'h4);
    check(msgCount == 0, "R5 no message when masked", msgCount, 0);

    // R6 unmask via table write delivers
    pushExp(A2, 32'h42);
    regWrite(12'h02C, 32'h0); idle(6);
    regRead(12'h800, rd); check(rd == 0, "R6 pending cleared", rd, 0);
    check(msgCount == 1, "R6 deferred message sent", msgCount, 1);

    // R4 unmasked request direct
    pushExp(A3, 32'h43);
    pulseIrq(3); idle(6);
    check(msgCount == 2, "R4 direct message", msgCount, 2);

    // R5 function mask
    ctrlWrite(8'hC0);
    check(ctrlRdData == 8'hC0, "R3 function mask readback", ctrlRdData, 8'hC0);
    pulseIrq(3); pulseIrq(2); idle(4);
    regRead(12'h800, rd); check(rd == 32'hC, "R5 function mask pends", rd, 32'hC);
    check(msgCount == 2, "R5 no message under function mask", msgCount, 2);

    // R7 clearing function mask drains lowest first
    pushExp(A2, 32'h42);
    pushExp(A3, 32'h43);
    ctrlWrite(8'h80); idle(8);
    regRead(12'h800, rd); check(rd == 0, "R7 pending drained", rd, 0);
    check(msgCount == 4, "R7 two messages drained", msgCount, 4);

    // R9 release clears pending
    regWrite(12'h02C, 32'h1);
    pulseIrq(2); idle(3);
    regRead(12'h800, rd); check(rd == 32'h4, "R9 pending before release", rd, 32'h4);
    @(negedge clk); vecRelease[2] = 1'b1;
    @(negedge clk); vecRelease = '0;
    idle(2);
    regRead(12'h800, rd); check(rd == 0, "R9 released", rd, 0);

    // R11 pending word read-only
    pulseIrq(2); idle(3);
    regWrite(12'h800, 32'h0);
    regRead(12'h800, rd); check(rd == 32'h4, "R11 pending write ignored", rd, 32'h4);
    @(negedge clk); vecRelease[2] = 1'b1;
    @(negedge clk); vecRelease = '0;

    // R10 backpressure
    msgReady = 1'b0;
    pushExp(A3, 32'h43);
    pulseIrq(3); idle(6);
    check(msgValid, "R10 valid held", msgValid, 1);
    check(msgAddr == A3, "R10 address held", msgAddr, A3);
    msgReady = 1'b1;
    idle(3);
    check(msgCount == 5, "R10 message after ready", msgCount, 5);

    // R8 disable again
    ic = intxCount; mc = msgCount;
    ctrlWrite(8'h00); idle(2);
    check(intxCount == ic, "R8 no intx when disabling", intxCount, ic);
    pulseIrq(3); idle(6);
    check(msgCount == mc, "R8 no message after disable", msgCount, mc);

    check(expQ.size() == 0, "R4 scoreboard empty", expQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule